// File: doc/BRIEF.md
# Operand Bus Sequencer

This block sits between a CPU execution unit and a 16-bit external data bus. The CPU hands it one operand request: a byte, a word or a long word, to be read or written at any byte address. The block breaks the request into bus cycles. A single cycle never moves more than one aligned 16-bit word.

For each cycle the block drives the following:
- the byte address;
- a two-bit code giving how many operand bytes are still outstanding;
- the two byte-lane strobes;
- the write data, placed on the lanes.

It then waits for the bus to acknowledge. Bytes returned by reads are merged into a right-justified result. When the last cycle is acknowledged, the block pulses a done strobe. Word and long-word operands at odd addresses are carried entirely by byte cycles. A misaligned long word is therefore handled as two misaligned words.

The CPU gives only the 20 low address bits. Bus address bits 23 to 20 are copies of bit 19. The state machine has three states:
- IDLE: ready for a request.
- BUS: a bus cycle is presented and the block waits for acknowledge.
- FINISH: a single-cycle done pulse.

The transitions are:
- IDLE→BUS when a request is accepted.
- BUS→BUS on an acknowledge that leaves bytes outstanding.
- BUS→FINISH on the acknowledge of the final cycle.
- FINISH→IDLE unconditionally.

Top module: `operand_bus_sequencer`

## Requirements
- R1: After reset the block is idle: req_ready=1, bus_req=0, done=0, and both lane strobes are 0.
- R2: A request is taken only while req_ready is high, which is the IDLE state. A req_valid raised while a transfer is in flight does not change the presented cycle or the rest of the sequence.
- R3: bus_siz gives the operand bytes still outstanding at the start of each cycle: 01 means one, 10 two, 11 three and 00 four. The operand size code on req_size is 00 for a byte, 01 for a word and 10 for a long word; 11 is taken as a long word.
- R4: The low 20 bits of bus_addr start at the request address and advance by the number of bytes each acknowledged cycle moved, wrapping modulo 2^20. Bits 23:20 always equal bit 19.
- R5: An aligned word is moved in one cycle with both lanes active. A byte at an even address uses only the high lane (bits 15:8). A byte at an odd address uses only the low lane (bits 7:0).
- R6: A word at an odd address is moved in two byte cycles. The first carries the most significant operand byte on the low lane at the odd address. The second carries the other byte on the high lane at the next even address.
- R7: A long word at an even address is moved in two word cycles, with the most significant word first.
- R8: A long word at an odd address is moved in four byte cycles. The lanes alternate low, high, low, high, and the bytes go most significant first.
- R9: During writes, each active lane carries its operand byte and an inactive lane carries 00. bus_write is 1 throughout a write.
- R10: done is high for exactly one cycle, the cycle after the final acknowledge. rd_data then holds the read operand right-justified, with the first transferred byte most significant.
- R11: While bus_req is high and bus_ack is low, the address, size code, lanes and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code |
| req_addr | input | 20 | Operand byte address |
| req_wdata | input | 32 | Write operand, right-justified |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 32 | Read operand, right-justified |
| bus_req | output | 1 | Bus cycle presented |
| bus_ack | input | 1 | Bus cycle completed |
| bus_write | output | 1 | Presented cycle is a write |
| bus_addr | output | 24 | Byte address of the cycle |
| bus_siz | output | 2 | Outstanding byte count code |
| bus_lane_hi | output | 1 | Data bits 15:8 active |
| bus_lane_lo | output | 1 | Data bits 7:0 active |
| bus_wdata | output | 16 | Write data on the lanes |
| bus_rdata | input | 16 | Read data from the bus |

## Verification
Some properties are checked by the assertions on every cycle:
- the relation between lane strobes and address parity;
- the mirroring of the high address bits;
- the address advance and size-code decrease from one acknowledged cycle to the next;
- holding the cycle while the bus stalls;
- the single done pulse after the last acknowledge, and mutual exclusion of idle with bus activity.

Other behaviour only the bench scenarios can show:
- which operand byte lands on which lane;
- the right-justified assembly of read data;
- the exact number of cycles for each size and alignment;
- that requests raised during a stall leave the sequence unchanged.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

    typedef enum logic [1:0] {
        OPSZ_BYTE = 2'b00,
        OPSZ_WORD = 2'b01,
        OPSZ_LONG = 2'b10
    } opsz_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUS    = 2'd1,
        ST_FINISH = 2'd2
    } seq_state_e;

    localparam int OPND_BYTES = 4;

    // operand length in bytes for a request size code (11 behaves as long)
    function automatic logic [2:0] opsz_bytes(input logic [1:0] sz);
        case (sz)
            OPSZ_BYTE: opsz_bytes = 3'd1;
            OPSZ_WORD: opsz_bytes = 3'd2;
            default:   opsz_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/opseq_plan.sv
// Decides the shape of the current bus cycle from alignment and count left.
module opseq_plan (
    input  logic       addr_odd,
    input  logic [2:0] remaining,
    input  logic       misaligned,
    output logic       two_lane,
    output logic       lane_hi,
    output logic       lane_lo,
    output logic [1:0] siz
);
    always_comb begin
        two_lane = !misaligned && !addr_odd && (remaining >= 3'd2);
        lane_hi  = two_lane || !addr_odd;
        lane_lo  = two_lane || addr_odd;
        siz      = remaining[1:0];
    end
endmodule

// File: rtl/opseq_ctrl.sv
module opseq_ctrl
    import opseq_pkg::*;
#(
    parameter int LIVE_AW = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [LIVE_AW-1:0] req_addr,
    input  logic               bus_ack,
    input  logic               two_lane,
    output logic               req_ready,
    output logic               bus_req,
    output logic               done,
    output logic               load,
    output logic               step,
    output logic               wr_flag,
    output logic               misaligned,
    output logic [2:0]         remaining,
    output logic [LIVE_AW-1:0] cur_addr
);
    seq_state_e state_q, state_d;
    logic [2:0] moved;
    logic       last;
    logic [2:0] req_len;

    always_comb begin
        req_len = opsz_bytes(req_size);
        moved   = two_lane ? 3'd2 : 3'd1;
        last    = (remaining == moved);
        load    = (state_q == ST_IDLE) && req_valid;
        step    = (state_q == ST_BUS) && bus_ack;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_BUS;
            ST_BUS:    if (bus_ack && last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        bus_req   = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_BUS:    bus_req   = 1'b1;
            ST_FINISH: done      = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    // transfer bookkeeping: address, bytes outstanding, alignment class
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            remaining  <= 3'd0;
            misaligned <= 1'b0;
            wr_flag    <= 1'b0;
        end else if (load) begin
            cur_addr   <= req_addr;
            remaining  <= req_len;
            misaligned <= (req_len != 3'd1) && req_addr[0];
            wr_flag    <= req_write;
        end else if (step) begin
            cur_addr   <= cur_addr + LIVE_AW'(moved);
            remaining  <= remaining - moved;
        end
    end
endmodule

// File: rtl/opseq_wmux.sv
// Write lane steering: operand kept left-aligned, consumed from the top.
module opseq_wmux
    import opseq_pkg::*;
#(
    parameter int OPND_W = 32,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [1:0]        req_size,
    input  logic [OPND_W-1:0] req_wdata,
    input  logic              two_lane,
    input  logic              lane_lo,
    output logic [BUS_W-1:0]  bus_wdata
);
    localparam int BYTE_W = 8;
    logic [OPND_W-1:0] wsh;
    logic [BYTE_W-1:0] top_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wsh <= '0;
        end else if (load) begin
            case (opsz_bytes(req_size))
                3'd1:    wsh <= req_wdata << (OPND_W - BYTE_W);
                3'd2:    wsh <= req_wdata << (OPND_W - BUS_W);
                default: wsh <= req_wdata;
            endcase
        end else if (step) begin
            wsh <= two_lane ? (wsh << BUS_W) : (wsh << BYTE_W);
        end
    end

    always_comb begin
        top_byte = wsh[OPND_W-1 -: BYTE_W];
        if (two_lane)     bus_wdata = wsh[OPND_W-1 -: BUS_W];
        else if (lane_lo) bus_wdata = {{(BUS_W-BYTE_W){1'b0}}, top_byte};
        else              bus_wdata = {top_byte, {(BUS_W-BYTE_W){1'b0}}};
    end
endmodule

// File: rtl/opseq_rasm.sv
// Read assembly: returned bytes shifted in from the right.
module opseq_rasm #(
    parameter int OPND_W = 32,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic              two_lane,
    input  logic              lane_lo,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic [OPND_W-1:0] rd_data
);
    localparam int BYTE_W = 8;
    logic [BYTE_W-1:0] lane_byte;

    always_comb lane_byte = lane_lo ? bus_rdata[BYTE_W-1:0] : bus_rdata[BUS_W-1 -: BYTE_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (load)    rd_data <= '0;
        else if (capture) begin
            if (two_lane) rd_data <= {rd_data[OPND_W-BUS_W-1:0], bus_rdata};
            else          rd_data <= {rd_data[OPND_W-BYTE_W-1:0], lane_byte};
        end
    end
endmodule

// File: rtl/operand_bus_sequencer.sv
module operand_bus_sequencer #(
    parameter int BUS_AW  = 24,
    parameter int LIVE_AW = 20,
    parameter int OPND_W  = 32,
    parameter int BUS_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [LIVE_AW-1:0] req_addr,
    input  logic [OPND_W-1:0]  req_wdata,
    output logic               done,
    output logic [OPND_W-1:0]  rd_data,
    output logic               bus_req,
    input  logic               bus_ack,
    output logic               bus_write,
    output logic [BUS_AW-1:0]  bus_addr,
    output logic [1:0]         bus_siz,
    output logic               bus_lane_hi,
    output logic               bus_lane_lo,
    output logic [BUS_W-1:0]   bus_wdata,
    input  logic [BUS_W-1:0]   bus_rdata
);
    localparam int MIRROR_W = BUS_AW - LIVE_AW;

    logic               load, step, wr_flag, misaligned;
    logic               two_lane, lane_hi, lane_lo;
    logic [2:0]         remaining;
    logic [LIVE_AW-1:0] cur_addr;
    logic [1:0]         siz;

    opseq_ctrl #(.LIVE_AW(LIVE_AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr),
        .bus_ack(bus_ack), .two_lane(two_lane),
        .req_ready(req_ready), .bus_req(bus_req), .done(done),
        .load(load), .step(step), .wr_flag(wr_flag),
        .misaligned(misaligned), .remaining(remaining), .cur_addr(cur_addr)
    );

    opseq_plan u_plan (
        .addr_odd(cur_addr[0]), .remaining(remaining), .misaligned(misaligned),
        .two_lane(two_lane), .lane_hi(lane_hi), .lane_lo(lane_lo), .siz(siz)
    );

    opseq_wmux #(.OPND_W(OPND_W), .BUS_W(BUS_W)) u_wmux (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .req_size(req_size), .req_wdata(req_wdata),
        .two_lane(two_lane), .lane_lo(lane_lo), .bus_wdata(bus_wdata)
    );

    opseq_rasm #(.OPND_W(OPND_W), .BUS_W(BUS_W)) u_rasm (
        .clk(clk), .rst_n(rst_n), .load(load),
        .capture(step && !wr_flag),
        .two_lane(two_lane), .lane_lo(lane_lo),
        .bus_rdata(bus_rdata), .rd_data(rd_data)
    );

    always_comb begin
        bus_addr    = {{MIRROR_W{cur_addr[LIVE_AW-1]}}, cur_addr};
        bus_siz     = siz;
        bus_lane_hi = bus_req && lane_hi;
        bus_lane_lo = bus_req && lane_lo;
        bus_write   = bus_req && wr_flag;
    end
endmodule

// File: rtl/opseq_checks.sv
module opseq_checks #(
    parameter int BUS_AW  = 24,
    parameter int LIVE_AW = 20,
    parameter int BUS_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic              bus_req,
    input logic              bus_ack,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [1:0]        bus_siz,
    input logic              bus_lane_hi,
    input logic              bus_lane_lo,
    input logic [BUS_W-1:0]  bus_wdata
);
    logic [1:0] moved;
    logic       last_cyc;
    always_comb begin
        moved    = 2'(bus_lane_hi) + 2'(bus_lane_lo);
        last_cyc = (bus_siz == moved);
    end

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_req && !done));

    a_r4_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr[BUS_AW-1:LIVE_AW] == {(BUS_AW-LIVE_AW){bus_addr[LIVE_AW-1]}}));

    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !last_cyc) |=>
        (bus_req && bus_addr[LIVE_AW-1:0] ==
            LIVE_AW'($past(bus_addr[LIVE_AW-1:0]) + LIVE_AW'($past(moved)))));

    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !last_cyc) |=> (bus_siz == 2'($past(bus_siz) - $past(moved))));

    a_r5_lane_parity: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ((bus_lane_hi || bus_lane_lo) &&
                     (!(bus_lane_hi && bus_lane_lo) || !bus_addr[0]) &&
                     (!(bus_lane_lo && !bus_lane_hi) || bus_addr[0]) &&
                     (!(bus_lane_hi && !bus_lane_lo) || !bus_addr[0])));

    a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && last_cyc) |=> done);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_siz) &&
            $stable(bus_lane_hi) && $stable(bus_lane_lo) && $stable(bus_wdata)));
endmodule

bind operand_bus_sequencer opseq_checks #(.BUS_AW(BUS_AW), .LIVE_AW(LIVE_AW), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/test_operand_bus_sequencer.sv
`timescale 1ns/1ps
module test_operand_bus_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, done, bus_req, bus_write, bus_lane_hi, bus_lane_lo;
    logic [31:0] rd_data;
    logic        bus_ack = 1'b0;
    logic [23:0] bus_addr;
    logic [1:0]  bus_siz;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    int total = 0, bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    operand_bus_sequencer i_operand_bus_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
        .bus_req(bus_req), .bus_ack(bus_ack), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_siz(bus_siz), .bus_lane_hi(bus_lane_hi),
        .bus_lane_lo(bus_lane_lo), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] mirror(input logic [19:0] a);
        return {{4{a[19]}}, a};
    endfunction

    function automatic logic [7:0] opbyte(input logic [31:0] wd, input int n, input int k);
        logic [31:0] s;
        s = wd >> (8 * (n - 1 - k));
        return s[7:0];
    endfunction

    // one full operand transfer, bench acting as bus responder
    task automatic run_op(input bit wr, input logic [1:0] sz, input logic [19:0] addr,
                          input logic [31:0] wd, input int max_wait);
        int n, idx, nb, rem;
        bit mis, two;
        logic [19:0] cur;
        logic [1:0] exp_lanes;
        logic [15:0] exp_wd, rdat;
        logic [31:0] exp_rd;
        n = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        mis = (n > 1) && addr[0];
        idx = 0; cur = addr; exp_rd = '0;
        chk(req_ready == 1'b1, "R2 ready when idle", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (idx < n) begin
            int waits;
            rem = n - idx;
            two = !mis && !cur[0] && (rem >= 2);
            nb = two ? 2 : 1;
            exp_lanes = two ? 2'b11 : (cur[0] ? 2'b01 : 2'b10);
            if (two)       exp_wd = {opbyte(wd, n, idx), opbyte(wd, n, idx + 1)};
            else if (cur[0]) exp_wd = {8'h00, opbyte(wd, n, idx)};
            else           exp_wd = {opbyte(wd, n, idx), 8'h00};
            waits = $urandom_range(0, max_wait);
            rdat = 16'($urandom);
            for (int w = 0; w <= waits; w++) begin
                chk(bus_req == 1'b1, "R2 bus cycle presented", {31'd0, bus_req}, 32'd1);
                chk(bus_addr == mirror(cur), "R4 bus address", {8'd0, bus_addr}, {8'd0, mirror(cur)});
                chk(bus_siz == 2'(rem), "R3 remaining size code", {30'd0, bus_siz}, 32'(rem[1:0]));
                chk({bus_lane_hi, bus_lane_lo} == exp_lanes, "R5 R6 R7 R8 lanes",
                    {30'd0, bus_lane_hi, bus_lane_lo}, {30'd0, exp_lanes});
                chk(bus_write == wr, "R9 bus_write", {31'd0, bus_write}, {31'd0, wr});
                if (wr) chk(bus_wdata == exp_wd, "R9 write lanes", {16'd0, bus_wdata}, {16'd0, exp_wd});
                if (w == waits) begin
                    bus_ack = 1'b1; bus_rdata = rdat;
                end else begin
                    // stall cycle: stray request must be ignored (R2), cycle held (R11)
                    bus_rdata = 16'($urandom);
                    req_valid = 1'b1; req_write = ~wr; req_size = 2'($urandom);
                    req_addr = 20'($urandom); req_wdata = $urandom;
                end
                @(negedge clk);
                bus_ack = 1'b0; req_valid = 1'b0;
            end
            if (two)         exp_rd = {exp_rd[15:0], rdat};
            else if (cur[0]) exp_rd = {exp_rd[23:0], rdat[7:0]};
            else             exp_rd = {exp_rd[23:0], rdat[15:8]};
            idx += nb;
            cur = cur + 20'(nb);
        end
        chk(done == 1'b1, "R10 done after final ack", {31'd0, done}, 32'd1);
        chk(bus_req == 1'b0, "R10 bus idle at done", {31'd0, bus_req}, 32'd0);
        if (!wr) chk(rd_data == exp_rd, "R10 read assembly", rd_data, exp_rd);
        @(negedge clk);
        chk(done == 1'b0, "R10 done single cycle", {31'd0, done}, 32'd0);
        chk(req_ready == 1'b1, "R2 back to idle", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0c16));
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", {31'd0, req_ready}, 32'd1);
        chk(bus_req == 1'b0, "R1 no bus cycle in reset", {31'd0, bus_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && done == 1'b0, "R1 idle after reset",
            {30'd0, req_ready, done}, 32'd2);
        chk({bus_lane_hi, bus_lane_lo} == 2'b00, "R1 lanes off", {30'd0, bus_lane_hi, bus_lane_lo}, 32'd0);
        // directed corner cases
        run_op(1'b1, 2'b00, 20'h01000, 32'h0000_00A5, 0); // R5 even byte
        run_op(1'b1, 2'b00, 20'h01001, 32'h0000_005A, 0); // R5 odd byte
        run_op(1'b1, 2'b01, 20'h02000, 32'h0000_1234, 0); // R5 aligned word
        run_op(1'b1, 2'b01, 20'h02001, 32'h0000_ABCD, 1); // R6 misaligned word
        run_op(1'b0, 2'b01, 20'h02003, 32'h0, 2);          // R6 read
        run_op(1'b1, 2'b10, 20'h03000, 32'h1122_3344, 0); // R7
        run_op(1'b0, 2'b10, 20'h03000, 32'h0, 1);          // R7 read
        run_op(1'b1, 2'b10, 20'h03005, 32'h5566_7788, 0); // R8
        run_op(1'b0, 2'b10, 20'h7FFFF, 32'h0, 2);          // R8 R4 crossing bit 19
        run_op(1'b0, 2'b11, 20'hFFFFE, 32'h0, 0);          // R3 code 11 as long, R4 wrap
        run_op(1'b1, 2'b01, 20'hFFFFF, 32'h0000_BEEF, 2); // R4 wrap misaligned word
        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            run_op(1'($urandom), 2'($urandom_range(0, 2)), 20'($urandom), $urandom, 3);
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule